// File: doc/BRIEF.md
# Sensor Scratchpad Command Unit

This block runs the function layer of a single-wire temperature sensor once the addressing layer has selected the device. A front end that decodes bus timing hands it received bytes on a valid/ready channel, pulses `cmd_start` when addressing has finished, pulses `bus_reset` on every bus reset, and asks for one transmitted bit per read slot on `slot_req`. The unit holds a nine-byte readable scratchpad: a sign-extended temperature, the high and low alarm limits, two reserved bytes, a count-remain byte, a counts-per-degree byte and a CRC byte. It also keeps nonvolatile shadow copies of both limits as plain registers.

After `cmd_start` the next accepted byte is taken as a command. The unit starts a conversion, reads or writes the scratchpad, copies the limits to the shadow copies, recalls them, or reports the supply mode. Conversion and copy take a fixed number of clock cycles set by parameters. While either runs, read slots answer 0, and once it finishes they answer 1. When a conversion ends, the unit latches the temperature from `temp_in` and `cnt_in` and updates the alarm flag.

The byte channel applies back-pressure: `rx_ready` is high only while a command byte or a write byte is expected. A sender keeps `rx_valid` and `rx_data` steady until a cycle with both high, and that cycle consumes the byte. A byte offered at any other time is not consumed. The slot channel does not stall: each cycle with `slot_req` high is one slot, and the next cycle carries `slot_ack` high with the answer on `slot_bit`.

Top module: `scratch_cmd_unit`

## Requirements
- R1: After power-on reset the limits equal the shadow-copy initial values (`NV_TH_INIT`, `NV_TL_INIT`), the temperature and count-remain bytes are 00h, `alarm_flag` is 0, `rx_ready` is 0, and read slots answer 1.
- R2: `rx_ready` is high only after `cmd_start` (awaiting a command) or inside a scratchpad write. An unknown command byte is consumed and returns the unit to idle, where `rx_ready` is 0 and slots answer 1.
- R3: Command 4Eh writes exactly two bytes, the first to byte 2 (high limit) and the second to byte 3 (low limit). After the second byte `rx_ready` drops, so a third byte is not consumed. A bus reset after the first byte leaves byte 3 unchanged.
- R4: Command BEh sends bytes 0 to 8 in order, each least significant bit first. There is one bit per slot, and `slot_ack` rises in the cycle after each `slot_req`. Bytes 4 and 5 are FFh, byte 7 is `CNT_PER_DEG`, and slots after byte 8 answer 1.
- R5: Byte 8 is the CRC over bytes 0 to 7. It uses polynomial x^8+x^5+x^4+1, starts from a zero register, and is fed least significant bit first.
- R6: Command 44h makes exactly `CONV_CYCLES` consecutive slots answer 0 and later slots answer 1. Bytes 0 and 1 then hold the 9-bit `temp_in` (0.5 °C per LSB) sign-extended to 16 bits, and byte 6 holds `cnt_in`.
- R7: When a conversion ends, `alarm_flag` becomes 1 if `temp_in[8:1]`, read as a signed byte, is greater than the high limit or less than the low limit, both read as signed. Otherwise it becomes 0. The flag changes at no other time.
- R8: Command 48h copies bytes 2 and 3 into the shadow copies and makes exactly `COPY_CYCLES` consecutive slots answer 0, then 1.
- R9: Command B8h reloads bytes 2 and 3 from the shadow copies.
- R10: Command B4h makes every slot answer the value of `ext_power` (0 means powered from the bus, 1 means external supply).
- R11: A bus reset ends a read or write at once, and a later read restarts at byte 0 with a fresh CRC. A conversion already running finishes and updates the temperature despite the bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_reset | input | 1 | One-cycle pulse for a bus reset; aborts the current command |
| cmd_start | input | 1 | Addressing finished; the next byte is a command |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Unit can consume a byte this cycle |
| slot_req | input | 1 | One read slot requested this cycle |
| slot_ack | output | 1 | Answer for the previous cycle's slot is valid |
| slot_bit | output | 1 | Bit answered on the slot |
| temp_in | input | 9 | Two's-complement temperature, 0.5 °C per LSB, sampled at the end of a conversion |
| cnt_in | input | 8 | Count-remain value sampled at the end of a conversion |
| ext_power | input | 1 | 1 when externally supplied |
| alarm_flag | output | 1 | Result of the last limit comparison |

## Verification
The hardest behaviour to reach is the alarm comparison at its edges. The signed limits must be crossed from both sides, and the dropped half-degree bit must fall on each side of a limit. Each of these cases needs a full write, conversion and read-back sequence. The stimulus first writes a positive high limit and a negative low limit, then sweeps all 512 temperature codes through a conversion each. For every code it checks the busy length, the alarm flag, the sign extension and the CRC. A bus reset that cuts into a read or a write is a separate case: it is reached by starting a new command directly after a partial transfer.

// File: rtl/scu_pkg.sv
package scu_pkg;
  localparam int TEMP_W   = 9;
  localparam int PAD_LAST = 8;          // index of the CRC byte
  localparam logic [7:0] RESV_BYTE     = 8'hFF;
  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;  // x^8+x^5+x^4+1, shifted right

  localparam logic [7:0] OP_CONVERT = 8'h44;
  localparam logic [7:0] OP_RD_PAD  = 8'hBE;
  localparam logic [7:0] OP_WR_PAD  = 8'h4E;
  localparam logic [7:0] OP_COPY    = 8'h48;
  localparam logic [7:0] OP_RECALL  = 8'hB8;
  localparam logic [7:0] OP_PWR     = 8'hB4;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WRITE, S_READ, S_STAT, S_PWR
  } scu_state_e;
endpackage

// File: rtl/scu_crc8_ser.sv
module scu_crc8_ser
  import scu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [7:0] crc
);
  logic fb;
  assign fb = crc[0] ^ din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= (crc >> 1) ^ (fb ? CRC_POLY_REFL : 8'h00);
  end

  // R5: a fresh read always starts the CRC from zero
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 8'h00));
endmodule

// File: rtl/scu_op_timer.sv
module scu_op_timer #(
  parameter int CYCLES = 4,
  parameter int W      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (start && cnt == '0)     cnt <= W'(CYCLES);
    else if (cnt != '0)              cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);
  assign done = (cnt == W'(1));

  // R6 / R8: a start on an idle timer makes it busy
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R6 / R8: the last busy cycle is followed by idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/scratch_cmd_unit.sv
module scratch_cmd_unit
  import scu_pkg::*;
#(
  parameter int         CONV_CYCLES = 1000,
  parameter int         COPY_CYCLES = 200,
  parameter logic [7:0] NV_TH_INIT  = 8'h4B,
  parameter logic [7:0] NV_TL_INIT  = 8'hF6,
  parameter logic [7:0] CNT_PER_DEG = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              cmd_start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              slot_req,
  output logic              slot_ack,
  output logic              slot_bit,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic [7:0]        cnt_in,
  input  logic              ext_power,
  output logic              alarm_flag
);
  localparam int TMR_MAX = (CONV_CYCLES > COPY_CYCLES) ? CONV_CYCLES : COPY_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int IDX_W   = $clog2(PAD_LAST + 2);
  localparam logic [IDX_W-1:0] CRC_IDX  = IDX_W'(PAD_LAST);
  localparam logic [IDX_W-1:0] PAST_IDX = IDX_W'(PAD_LAST + 1);
  localparam int N_TMR = 2;   // 0: conversion, 1: copy

  scu_state_e       st;
  logic             stat_copy;
  logic             wr_idx;
  logic [IDX_W-1:0] rd_byte;
  logic [2:0]       rd_bit;
  logic [15:0]      temp_q;
  logic [7:0]       th_q, tl_q, nv_th, nv_tl, cnt_q;
  logic             alarm_q;
  logic [7:0]       crc_q;
  logic [7:0]       pad_byte;
  logic             slot_val;

  logic rx_fire, cmd_fire, wr_fire;
  logic conv_go, copy_go, recall_go, read_go;
  logic crc_en;
  logic [N_TMR-1:0] tmr_start, tmr_busy, tmr_done;

  assign rx_ready  = (st == S_CMD) || (st == S_WRITE);
  assign rx_fire   = rx_valid && rx_ready && !bus_reset;
  assign cmd_fire  = rx_fire && (st == S_CMD);
  assign wr_fire   = rx_fire && (st == S_WRITE);
  assign conv_go   = cmd_fire && (rx_data == OP_CONVERT);
  assign copy_go   = cmd_fire && (rx_data == OP_COPY);
  assign recall_go = cmd_fire && (rx_data == OP_RECALL);
  assign read_go   = cmd_fire && (rx_data == OP_RD_PAD);

  // ---------------- long operations ----------------
  assign tmr_start = {copy_go, conv_go};

  for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
    scu_op_timer #(
      .CYCLES (gi == 0 ? CONV_CYCLES : COPY_CYCLES),
      .W      (TMR_W)
    ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start[gi]),
      .busy  (tmr_busy[gi]),
      .done  (tmr_done[gi])
    );
  end

  // ---------------- command sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      stat_copy <= 1'b0;
      wr_idx    <= 1'b0;
      rd_byte   <= '0;
      rd_bit    <= '0;
    end else if (bus_reset) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (cmd_start) st <= S_CMD;
        S_CMD: if (rx_fire) begin
          case (rx_data)
            OP_CONVERT: begin st <= S_STAT; stat_copy <= 1'b0; end
            OP_COPY:    begin st <= S_STAT; stat_copy <= 1'b1; end
            OP_RD_PAD:  begin st <= S_READ; rd_byte <= '0; rd_bit <= '0; end
            OP_WR_PAD:  begin st <= S_WRITE; wr_idx <= 1'b0; end
            OP_PWR:     st <= S_PWR;
            default:    st <= S_IDLE;   // recall and unknown codes
          endcase
        end
        S_WRITE: if (rx_fire) begin
          wr_idx <= 1'b1;
          if (wr_idx) st <= S_IDLE;
        end
        S_READ: if (slot_req && rd_byte != PAST_IDX) begin
          rd_bit <= rd_bit + 3'd1;
          if (rd_bit == 3'd7) rd_byte <= rd_byte + IDX_W'(1);
        end
        default: ;
      endcase
    end
  end

  // ---------------- scratchpad and shadow copies ----------------
  logic signed [7:0] t_whole, th_s, tl_s;
  assign t_whole = temp_in[TEMP_W-1:1];
  assign th_s    = th_q;
  assign tl_s    = tl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q  <= '0;
      cnt_q   <= '0;
      alarm_q <= 1'b0;
      nv_th   <= NV_TH_INIT;
      nv_tl   <= NV_TL_INIT;
      th_q    <= NV_TH_INIT;   // power-on recall
      tl_q    <= NV_TL_INIT;
    end else begin
      if (tmr_done[0]) begin
        temp_q  <= {{(16-TEMP_W){temp_in[TEMP_W-1]}}, temp_in};
        cnt_q   <= cnt_in;
        alarm_q <= (t_whole > th_s) || (t_whole < tl_s);
      end
      if (copy_go) begin
        nv_th <= th_q;
        nv_tl <= tl_q;
      end
      if (recall_go) begin
        th_q <= nv_th;
        tl_q <= nv_tl;
      end else if (wr_fire) begin
        if (wr_idx) tl_q <= rx_data;
        else        th_q <= rx_data;
      end
    end
  end

  assign alarm_flag = alarm_q;

  // ---------------- serial read path ----------------
  always_comb begin
    case (rd_byte)
      IDX_W'(0): pad_byte = temp_q[7:0];
      IDX_W'(1): pad_byte = temp_q[15:8];
      IDX_W'(2): pad_byte = th_q;
      IDX_W'(3): pad_byte = tl_q;
      IDX_W'(6): pad_byte = cnt_q;
      IDX_W'(7): pad_byte = CNT_PER_DEG;
      CRC_IDX:   pad_byte = crc_q;
      default:   pad_byte = RESV_BYTE;
    endcase
  end

  assign crc_en = slot_req && (st == S_READ) && (rd_byte < CRC_IDX) && !bus_reset;

  scu_crc8_ser u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (read_go),
    .en    (crc_en),
    .din   (pad_byte[rd_bit]),
    .crc   (crc_q)
  );

  always_comb begin
    case (st)
      S_READ:  slot_val = (rd_byte == PAST_IDX) ? 1'b1 : pad_byte[rd_bit];
      S_STAT:  slot_val = stat_copy ? !tmr_busy[1] : !tmr_busy[0];
      S_PWR:   slot_val = ext_power;
      default: slot_val = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_ack <= 1'b0;
      slot_bit <= 1'b1;
    end else begin
      slot_ack <= slot_req;
      slot_bit <= slot_req ? slot_val : 1'b1;
    end
  end

  // R4: every slot request is answered in the next cycle
  p_slot_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req |=> slot_ack);
  // R3: the second write byte closes the write window
  p_write_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx) |=> !rx_ready);
  // R7: the alarm flag moves only when a conversion completes
  p_alarm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_done[0] |=> $stable(alarm_q));
  // R8: shadow copies change only on a copy command
  p_nv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_go |=> ($stable(nv_th) && $stable(nv_tl)));
endmodule

// File: tb/scratch_cmd_unit_tb.sv
module scratch_cmd_unit_tb_top;
  localparam int CONV_C = 20;
  localparam int COPY_C = 7;
  localparam logic [7:0] TH0 = 8'h4B;
  localparam logic [7:0] TL0 = 8'hF6;
  localparam logic [7:0] CPD = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0, cmd_start = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready;
  logic slot_req = 1'b0;
  logic slot_ack, slot_bit;
  logic [8:0] temp_in = '0;
  logic [7:0] cnt_in = '0;
  logic ext_power = 1'b0;
  logic alarm_flag;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  logic [15:0] e_temp = '0;
  logic [7:0]  e_th = TH0, e_tl = TL0, e_cnt = '0;

  always #2 clk = ~clk;   // 250 MHz

  scratch_cmd_unit #(
    .CONV_CYCLES(CONV_C), .COPY_CYCLES(COPY_C),
    .NV_TH_INIT(TH0), .NV_TL_INIT(TL0), .CNT_PER_DEG(CPD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .cmd_start(cmd_start),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .slot_req(slot_req), .slot_ack(slot_ack), .slot_bit(slot_bit),
    .temp_in(temp_in), .cnt_in(cnt_in), .ext_power(ext_power),
    .alarm_flag(alarm_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(input logic [63:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 64; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] pad_ref();
    return {CPD, e_cnt, 8'hFF, 8'hFF, e_tl, e_th, e_temp[15:8], e_temp[7:0]};
  endfunction

  task automatic send_byte(input logic [7:0] b, output bit took);
    took = 0; rx_data = b; rx_valid = 1'b1;
    for (int i = 0; i < 4 && !took; i++) begin
      if (rx_ready) took = 1;
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  task automatic open_cmd(input logic [7:0] op, output bit took);
    bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
    cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
    send_byte(op, took);
  endtask

  task automatic read_bits(input int n, output logic [95:0] v, output bit ack_ok);
    v = '1; ack_ok = 1; slot_req = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      v[i] = slot_bit;
      if (!slot_ack) ack_ok = 0;
    end
    slot_req = 1'b0;
  endtask

  task automatic count_busy(output int z);
    z = 0; slot_req = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (slot_bit == 1'b0) z++;
      else break;
    end
    slot_req = 1'b0;
  endtask

  task automatic check_pad(input string req);
    logic [95:0] v; bit ok; bit took;
    open_cmd(8'hBE, took);
    read_bits(80, v, ok);
    chk(ok && took, "R4", {62'd0, took, ok}, 64'h3);
    chk(v[63:0] == pad_ref(), req, v[63:0], pad_ref());
    chk(v[71:64] == crc_ref(pad_ref()), "R5", v[71:64], crc_ref(pad_ref()));
    chk(v[79:72] == 8'hFF, "R4", v[79:72], 8'hFF);
  endtask

  task automatic write_lim(input logic [7:0] h, input logic [7:0] l);
    bit t0, t1, t2;
    open_cmd(8'h4E, t0); send_byte(h, t1); send_byte(l, t2);
    chk(t0 && t1 && t2, "R3", {61'd0, t0, t1, t2}, 64'h7);
    e_th = h; e_tl = l;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [95:0] v; bit ok, took; int z;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(alarm_flag == 1'b0, "R1", alarm_flag, 0);
    chk(rx_ready == 1'b0, "R1", rx_ready, 0);
    read_bits(6, v, ok);
    chk(v[5:0] == 6'h3F, "R1", v[5:0], 6'h3F);
    check_pad("R1");
    // R4: reserved bytes and constant byte explicitly
    chk(pad_ref()[47:32] == 16'hFFFF && pad_ref()[63:56] == CPD, "R4", pad_ref(), pad_ref());

    // R3: write window, third byte refused
    write_lim(8'h14, 8'h05);
    chk(rx_ready == 1'b0, "R3", rx_ready, 0);
    send_byte(8'h77, took);
    chk(took == 0, "R3", took, 0);
    check_pad("R3");
    // R3 / R11: bus reset after the first write byte
    open_cmd(8'h4E, took);
    send_byte(8'h33, took);
    e_th = 8'h33;
    check_pad("R11");

    // R10: supply mode query
    ext_power = 1'b0;
    open_cmd(8'hB4, took); read_bits(8, v, ok);
    chk(v[7:0] == 8'h00, "R10", v[7:0], 8'h00);
    ext_power = 1'b1;
    open_cmd(8'hB4, took); read_bits(8, v, ok);
    chk(v[7:0] == 8'hFF, "R10", v[7:0], 8'hFF);

    // R2: unknown command
    open_cmd(8'hA5, took);
    chk(took == 1, "R2", took, 1);
    chk(rx_ready == 1'b0, "R2", rx_ready, 0);
    read_bits(8, v, ok);
    chk(v[7:0] == 8'hFF, "R2", v[7:0], 8'hFF);

    // R8 / R9: copy, overwrite, recall
    write_lim(8'h19, 8'hE7);
    open_cmd(8'h48, took);
    count_busy(z);
    chk(z == COPY_C, "R8", z, COPY_C);
    write_lim(8'h01, 8'h02);
    check_pad("R3");
    open_cmd(8'hB8, took);
    e_th = 8'h19; e_tl = 8'hE7;
    check_pad("R9");

    // R11: read cut short, then restarted
    open_cmd(8'hBE, took);
    read_bits(12, v, ok);
    chk(v[11:0] == pad_ref()[11:0], "R4", v[11:0], pad_ref()[11:0]);
    check_pad("R11");

    // R6 / R7: sweep every temperature code
    write_lim(8'h14, 8'hF6);   // +20, -10
    for (int t = 0; t < 512; t++) begin
      logic signed [7:0] w;
      logic exp_al;
      temp_in = 9'(t);
      cnt_in  = 8'(t * 3 + 1);
      open_cmd(8'h44, took);
      count_busy(z);
      chk(z == CONV_C, "R6", z, CONV_C);
      w = 8'(t >> 1);
      exp_al = (w > 8'sd20) || (w < -8'sd10);
      chk(alarm_flag == exp_al, "R7", alarm_flag, exp_al);
      e_temp = {{7{temp_in[8]}}, temp_in};
      e_cnt  = cnt_in;
      check_pad("R6");
    end

    // R11: conversion completes across a bus reset
    temp_in = 9'h1F3;
    cnt_in  = 8'h5A;
    open_cmd(8'h44, took);
    bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
    repeat (CONV_C + 5) @(negedge clk);
    e_temp = 16'hFFF3; e_cnt = 8'h5A;
    check_pad("R11");

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule